// File: doc/BRIEF.md
# Pipeline Hazard Resolution Unit

This block decides, every cycle, how a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) handles register dependencies. It has two jobs. For each of the two ALU operands of the execute-stage instruction, it chooses whether the value comes from the memory-stage result, the writeback-stage result or the register file. It also produces the front-end stall and the squash of the fetched instruction.

A stall freezes the PC and the fetch/decode register, and it replaces the decode/execute entry with a bubble. There are two causes of a stall. The first is a load in execute whose result is needed by the instruction in decode. The second is a branch or register-indirect jump in decode whose operands are still being produced. No value is forwarded into decode. A control-flow instruction therefore waits there until the producer has reached writeback, where the register file makes the value readable in the same cycle.

When a control-flow instruction in decode resolves as taken, only the fetch/decode register is squashed. A stall always overrides that squash, and the squash is issued once the stall clears. The block is purely combinational. Its clock and reset serve only its built-in checks.

Top module: `hazardUnit`

## Requirements
- R1: An execute operand whose source register equals an enabled, nonzero memory-stage destination gets select code 2'b10 (memory result), even if the writeback stage also matches.
- R2: An execute operand that matches an enabled, nonzero writeback destination but not the memory stage gets select code 2'b01 (writeback result).
- R3: Any other execute operand gets select code 2'b00 (register file). A destination whose write-enable is low never matches.
- R4: Register 0 never causes forwarding or a stall, even when a stage reports it as an enabled destination.
- R5: An enabled load in execute whose destination equals the decode-stage rs or rt raises both stallFront and bubbleEx.
- R6: A non-load in execute whose destination matches a source of a non-control decode instruction raises no stall.
- R7: A decode-stage branch/JR with a source that equals an enabled, nonzero destination in execute or memory raises stallFront and bubbleEx.
- R8: A decode-stage branch/JR whose only matching producer is in writeback raises no stall.
- R9: flushIfId is high exactly when the decode instruction is a control-flow instruction, it is taken, and no stall is raised. A stall suppresses the flush.
- R10: A not-taken control-flow instruction, or any instruction not flagged as control flow, never raises flushIfId.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded checks |
| rst_n | input | 1 | Active-low reset for the embedded checks |
| idRs | input | 5 | Decode-stage first source register |
| idRt | input | 5 | Decode-stage second source register |
| idIsCtl | input | 1 | Decode instruction is a branch or JR |
| idCtlTaken | input | 1 | Decode control-flow instruction resolves as taken |
| exRs | input | 5 | Execute-stage first source register |
| exRt | input | 5 | Execute-stage second source register |
| exRd | input | 5 | Execute-stage destination |
| exWe | input | 1 | Execute-stage write-enable |
| exIsLoad | input | 1 | Execute instruction is a load |
| memRd | input | 5 | Memory-stage destination |
| memWe | input | 1 | Memory-stage write-enable |
| wbRd | input | 5 | Writeback-stage destination |
| wbWe | input | 1 | Writeback-stage write-enable |
| fwdSelA | output | 2 | Operand A source: 00 regfile, 01 writeback, 10 memory |
| fwdSelB | output | 2 | Operand B source, same coding |
| stallFront | output | 1 | Hold PC and fetch/decode register |
| bubbleEx | output | 1 | Zero the decode/execute register |
| flushIfId | output | 1 | Squash the fetch/decode register |

## Verification
The stall and the squash can both be requested in one cycle. This happens when a taken branch in decode depends on a load or ALU result still in execute or memory. The bench sets up exactly that case. It checks that stallFront and bubbleEx rise while flushIfId stays low, and that the flush appears once the producer has moved to writeback. A second overlap is between forwarding and stalling: a load in execute can feed the decode instruction while the execute operands forward from memory. The bench judges the select codes and the stall together in such cycles, in both directed and random traffic.

// File: rtl/hazPkg.sv
package hazPkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } fwdSel_e;

  typedef struct packed {
    logic stall;
    logic flush;
  } ctlStrobes_t;
endpackage

// File: rtl/fwdDatapath.sv
module fwdDatapath #(
  parameter int REG_COUNT = 32,
  localparam int AW = $clog2(REG_COUNT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0][AW-1:0]   exSrc,
  input  logic [AW-1:0]        memRd,
  input  logic                 memWe,
  input  logic [AW-1:0]        wbRd,
  input  logic                 wbWe,
  output hazPkg::fwdSel_e [1:0] sel
);
  import hazPkg::*;

  logic memLive, wbLive;
  assign memLive = memWe && (memRd != '0);
  assign wbLive  = wbWe && (wbRd != '0);

  for (genvar g = 0; g < 2; g++) begin : gOperand
    always_comb begin
      if (memLive && memRd == exSrc[g])     sel[g] = SEL_MEM;
      else if (wbLive && wbRd == exSrc[g])  sel[g] = SEL_WB;
      else                                  sel[g] = SEL_RF;
    end

    // R1: a memory-stage match wins over writeback
    assert_mem_priority_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (memWe && memRd == exSrc[g] && exSrc[g] != '0) |-> sel[g] == SEL_MEM);
    // R4: register zero is never forwarded
    assert_zero_no_fwd_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (exSrc[g] == '0) |-> sel[g] == SEL_RF);
  end
endmodule

// File: rtl/stallControl.sv
module stallControl #(
  parameter int REG_COUNT = 32,
  localparam int AW = $clog2(REG_COUNT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       idRs,
  input  logic [AW-1:0]       idRt,
  input  logic                idIsCtl,
  input  logic                idCtlTaken,
  input  logic [AW-1:0]       exRd,
  input  logic                exWe,
  input  logic                exIsLoad,
  input  logic [AW-1:0]       memRd,
  input  logic                memWe,
  output hazPkg::ctlStrobes_t strobes
);
  logic exHitsId, memHitsId, loadUse, ctlWait;

  always_comb begin
    exHitsId  = exWe && (exRd != '0) && (exRd == idRs || exRd == idRt);
    memHitsId = memWe && (memRd != '0) && (memRd == idRs || memRd == idRt);
    loadUse   = exIsLoad && exHitsId;
    ctlWait   = idIsCtl && (exHitsId || memHitsId);
    strobes.stall = loadUse || ctlWait;
    strobes.flush = idIsCtl && idCtlTaken && !strobes.stall;
  end

  // R5: load feeding decode must stall
  assert_load_use_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (exWe && exIsLoad && exRd != '0 && exRd == idRs) |-> strobes.stall);
  // R7: branch waiting on memory-stage producer
  assert_ctl_mem_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (idIsCtl && memWe && memRd != '0 && memRd == idRt) |-> strobes.stall);
  // R9: stall overrides flush
  assert_stall_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobes.stall && strobes.flush));
  // R10: no flush unless a taken control instruction
  assert_flush_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.flush |-> (idIsCtl && idCtlTaken));
endmodule

// File: rtl/hazardUnit.sv
module hazardUnit #(
  parameter int REG_COUNT = 32,
  localparam int AW = $clog2(REG_COUNT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] idRs,
  input  logic [AW-1:0] idRt,
  input  logic          idIsCtl,
  input  logic          idCtlTaken,
  input  logic [AW-1:0] exRs,
  input  logic [AW-1:0] exRt,
  input  logic [AW-1:0] exRd,
  input  logic          exWe,
  input  logic          exIsLoad,
  input  logic [AW-1:0] memRd,
  input  logic          memWe,
  input  logic [AW-1:0] wbRd,
  input  logic          wbWe,
  output logic [1:0]    fwdSelA,
  output logic [1:0]    fwdSelB,
  output logic          stallFront,
  output logic          bubbleEx,
  output logic          flushIfId
);
  import hazPkg::*;

  fwdSel_e [1:0]   selPair;
  ctlStrobes_t     strobes;

  fwdDatapath #(.REG_COUNT(REG_COUNT)) i_fwd (
    .clk(clk), .rst_n(rst_n),
    .exSrc({exRt, exRs}),
    .memRd(memRd), .memWe(memWe),
    .wbRd(wbRd), .wbWe(wbWe),
    .sel(selPair)
  );

  stallControl #(.REG_COUNT(REG_COUNT)) i_ctl (
    .clk(clk), .rst_n(rst_n),
    .idRs(idRs), .idRt(idRt),
    .idIsCtl(idIsCtl), .idCtlTaken(idCtlTaken),
    .exRd(exRd), .exWe(exWe), .exIsLoad(exIsLoad),
    .memRd(memRd), .memWe(memWe),
    .strobes(strobes)
  );

  assign fwdSelA    = selPair[0];
  assign fwdSelB    = selPair[1];
  assign stallFront = strobes.stall;
  assign bubbleEx   = strobes.stall;
  assign flushIfId  = strobes.flush;

  // R8: a writeback-only producer never stalls a branch
  assert_wb_no_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (idIsCtl && !exWe && !memWe) |-> !stallFront);
endmodule

// File: tb/test_hazardUnit.sv
module test_hazardUnit;
  logic clk = 0, rst_n = 0;
  logic [4:0] idRs, idRt, exRs, exRt, exRd, memRd, wbRd;
  logic idIsCtl, idCtlTaken, exWe, exIsLoad, memWe, wbWe;
  logic [1:0] fwdSelA, fwdSelB;
  logic stallFront, bubbleEx, flushIfId;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  hazardUnit i_hazardUnit (.*);

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  function automatic logic [1:0] refSel(input logic [4:0] src);
    if (memWe && memRd != 0 && memRd == src) return 2'b10;
    if (wbWe && wbRd != 0 && wbRd == src) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic refStall();
    logic exHit, memHit;
    exHit  = exWe && exRd != 0 && (exRd == idRs || exRd == idRt);
    memHit = memWe && memRd != 0 && (memRd == idRs || memRd == idRt);
    return (exIsLoad && exHit) || (idIsCtl && (exHit || memHit));
  endfunction

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    logic st;
    st = refStall();
    chk({tag, " selA R1 R2 R3 R4"}, fwdSelA, refSel(exRs));
    chk({tag, " selB R1 R2 R3 R4"}, fwdSelB, refSel(exRt));
    chk({tag, " stall R5 R6 R7 R8"}, {1'b0, stallFront}, {1'b0, st});
    chk({tag, " bubble R5 R7"}, {1'b0, bubbleEx}, {1'b0, st});
    chk({tag, " flush R9 R10"}, {1'b0, flushIfId}, {1'b0, idIsCtl && idCtlTaken && !st});
  endtask

  task automatic clearIn();
    {idRs, idRt, exRs, exRt, exRd, memRd, wbRd} = '0;
    {idIsCtl, idCtlTaken, exWe, exIsLoad, memWe, wbWe} = '0;
  endtask

  task automatic step(input string tag);
    @(negedge clk);
    compareAll(tag);
    @(posedge clk);
    #1;
  endtask

  initial begin
    clearIn();
    @(negedge clk);
    compareAll("reset R3");
    repeat (2) @(posedge clk);
    rst_n = 1;
    #1;
    // R1: both MEM and WB match, MEM wins
    exRs = 3; exRt = 3; memRd = 3; memWe = 1; wbRd = 3; wbWe = 1;
    step("R1");
    chk("R1 direct", fwdSelA, 2'b10);
    // R2: only WB matches
    clearIn(); exRs = 4; exRt = 7; wbRd = 7; wbWe = 1; memRd = 9; memWe = 1;
    step("R2");
    chk("R2 direct", fwdSelB, 2'b01);
    // R3: disabled write does not match
    clearIn(); exRs = 5; memRd = 5; wbRd = 5;
    step("R3");
    chk("R3 direct", fwdSelA, 2'b00);
    // R4: register zero
    clearIn(); memRd = 0; memWe = 1; exWe = 1; exIsLoad = 1; exRd = 0; idIsCtl = 1;
    step("R4");
    chk("R4 direct stall", {1'b0, stallFront}, 2'b00);
    // R5: load-use on rt
    clearIn(); exWe = 1; exIsLoad = 1; exRd = 8; idRt = 8;
    step("R5");
    chk("R5 direct", {1'b0, stallFront && bubbleEx}, 2'b01);
    // R6: ALU producer feeding non-control consumer
    exIsLoad = 0;
    step("R6");
    chk("R6 direct", {1'b0, stallFront}, 2'b00);
    // R7 + R9: taken branch depends on EX producer -> stall wins over flush
    clearIn(); idIsCtl = 1; idCtlTaken = 1; idRs = 6; exRd = 6; exWe = 1;
    step("R7 EX");
    chk("R9 stall wins", {stallFront, flushIfId}, 2'b10);
    // producer moves to MEM: still waiting
    exRd = 0; exWe = 0; memRd = 6; memWe = 1;
    step("R7 MEM");
    chk("R7 direct", {1'b0, stallFront}, 2'b01);
    // R8: producer now in WB: no stall, flush released
    memRd = 0; memWe = 0; wbRd = 6; wbWe = 1;
    step("R8");
    chk("R8 R9 direct", {stallFront, flushIfId}, 2'b01);
    // R10: not taken
    idCtlTaken = 0;
    step("R10");
    chk("R10 direct", {1'b0, flushIfId}, 2'b00);
    // R10: taken flag without control flag
    idIsCtl = 0; idCtlTaken = 1;
    step("R10 nonctl");
    chk("R10 nonctl direct", {1'b0, flushIfId}, 2'b00);
    // overlap: load-use stall with MEM forwarding on EX operands
    clearIn(); exWe = 1; exIsLoad = 1; exRd = 2; idRs = 2; exRs = 1; memRd = 1; memWe = 1;
    step("R5 R1 overlap");
    // random traffic over a small register range for frequent matches
    for (int i = 0; i < 3000; i++) begin
      idRs = 5'($urandom_range(0, 3)); idRt = 5'($urandom_range(0, 3));
      exRs = 5'($urandom_range(0, 3)); exRt = 5'($urandom_range(0, 3));
      exRd = 5'($urandom_range(0, 3)); memRd = 5'($urandom_range(0, 3));
      wbRd = 5'($urandom_range(0, 3));
      {idIsCtl, idCtlTaken, exWe, exIsLoad, memWe, wbWe} = 6'($urandom);
      step("random");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule